// File: doc/BRIEF.md
# Single-Stage Rank-Select Sorter

This block takes a group of unsigned words and returns them in sorted order. It has no cascade of two-input compare-exchange cells. All pairs of inputs are compared in parallel. Each input then counts how many of the others must be placed ahead of it, and that count is its rank. Each output lane is built as a sum of products: every input word is ANDed with the term "this input's rank equals this lane", and the results are ORed together. Equal values are ordered by input index, with the lower index placed first. So the ranks always form a permutation and exactly one input drives each lane.

The group enters and leaves through a valid/ready stream. An input group is accepted on a clock edge where `in_valid` and `in_ready` are both high. In the default registered mode, the sorted group is held in an output register. It stays there, unchanged, until a rising edge where `out_valid` and `out_ready` are both high. While a group is held and the consumer stalls, `in_ready` is low. When the consumer accepts the held group, a new group can be accepted on the same edge. With `OUT_REG=0` the block is purely combinational: valid and ready pass straight through it. The sort direction is chosen by a parameter. Lane `k` occupies bits `[k*W +: W]` of each flat data bus.

Top module: `nsort_top`

## Requirements
- R1: With `DESCEND=0`, each accepted group appears on `out_data` in non-decreasing order. Lane 0 (bits `[W-1:0]`) holds the minimum.
- R2: The output group is a permutation of the input group, with every duplicate kept.
- R3: If all inputs are equal, every output lane carries that value.
- R4: With `DESCEND=1`, the output is non-increasing and lane 0 holds the maximum.
- R5: For every output lane, exactly one input's rank matches that lane.
- R6: With `OUT_REG=1`, `out_valid` is high in the cycle after an edge where `in_valid && in_ready`. It then carries that group's sorted result.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged into the next cycle.
- R8: `in_ready` is low only while a held result waits with `out_ready` low.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.
- R10: The default configuration sorts 16 lanes of 32-bit values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Block can take an input group |
| in_data | input | N*W | Unsorted lanes, lane k at [k*W +: W] |
| out_valid | output | 1 | Sorted group valid |
| out_ready | input | 1 | Consumer accepts the sorted group |
| out_data | output | N*W | Sorted lanes, lane k at [k*W +: W] |

## Verification
An input group is driven at a falling edge and accepted on the next rising edge. Its sorted result is in the output register right after that edge. The bench therefore samples `out_valid` and `out_data` at the falling edge that follows, one cycle after the stimulus. In the back-pressure case, the bench holds `out_ready` low for several cycles. It checks at each falling edge that the held group has not changed and that `in_ready` stays low. It then releases `out_ready` and checks the next group one cycle after the edge that both drains the old group and accepts the new one.

// File: rtl/nsort_pkg.sv
package nsort_pkg;
  // Width needed to hold a rank in the range 0..n-1 (at least one bit).
  function automatic int rank_bits(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nsort_pairs.sv
// Comparator matrix. Every pair of lanes is compared once.
// precede[r][c] is 1 when lane c must be placed ahead of lane r.
module nsort_pairs #(
  parameter int N       = 16,
  parameter int W       = 32,
  parameter bit DESCEND = 1'b0
) (
  input  logic [W-1:0]         lane [N],
  output logic [N-1:0][N-1:0]  precede
);
  // lo_first[a][b] is meaningful only for a < b.
  // It is 1 when lane a goes ahead of lane b; on a tie the lower index wins.
  logic [N-1:0][N-1:0] lo_first;

  genvar a, b;
  generate
    for (a = 0; a < N; a++) begin : g_a
      for (b = 0; b < N; b++) begin : g_b
        if (a < b) begin : g_cmp
          if (DESCEND) begin : g_dn
            assign lo_first[a][b] = (lane[a] >= lane[b]);
          end else begin : g_up
            assign lo_first[a][b] = (lane[a] <= lane[b]);
          end
        end else begin : g_nil
          assign lo_first[a][b] = 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        if (r == c)     precede[r][c] = 1'b0;
        else if (c < r) precede[r][c] = lo_first[c][r];
        else            precede[r][c] = ~lo_first[r][c];
      end
    end
  end
endmodule

// File: rtl/nsort_rank.sv
// Rank of each lane: the number of lanes that must be placed ahead of it.
module nsort_rank #(
  parameter int N  = 16,
  parameter int RW = 4
) (
  input  logic [N-1:0][N-1:0]  precede,
  output logic [N-1:0][RW-1:0] rank
);
  genvar r;
  generate
    for (r = 0; r < N; r++) begin : g_row
      always_comb begin
        rank[r] = '0;
        for (int c = 0; c < N; c++) begin
          rank[r] = rank[r] + RW'(precede[r][c]);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/nsort_sop_mux.sv
// Sum-of-products output stage: output lane k is the OR over all inputs i
// of (input i AND rank[i] == k).
module nsort_sop_mux #(
  parameter int N  = 16,
  parameter int W  = 32,
  parameter int RW = 4
) (
  input  logic [W-1:0]         lane [N],
  input  logic [N-1:0][RW-1:0] rank,
  output logic [N-1:0][N-1:0]  sel,
  output logic [N*W-1:0]       sorted
);
  genvar k, i;
  generate
    for (k = 0; k < N; k++) begin : g_out
      for (i = 0; i < N; i++) begin : g_in
        assign sel[k][i] = (rank[i] == RW'(k));
      end
      always_comb begin
        sorted[k*W +: W] = '0;
        for (int j = 0; j < N; j++) begin
          sorted[k*W +: W] = sorted[k*W +: W] | (lane[j] & {W{sel[k][j]}});
        end
      end
    end
  endgenerate
endmodule

// File: rtl/nsort_top.sv
module nsort_top #(
  parameter int N       = 16,
  parameter int W       = 32,
  parameter bit DESCEND = 1'b0,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N*W-1:0] out_data
);
  localparam int RW = nsort_pkg::rank_bits(N);

  initial begin
    if (N < 3) $error("nsort_top: N must be at least 3");
  end

  logic [W-1:0]         lane [N];
  logic [N-1:0][N-1:0]  precede;
  logic [N-1:0][RW-1:0] rank;
  logic [N-1:0][N-1:0]  sel;
  logic [N*W-1:0]       sorted;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_unpack
      assign lane[g] = in_data[g*W +: W];
    end
  endgenerate

  nsort_pairs #(.N(N), .W(W), .DESCEND(DESCEND)) u_pairs (
    .lane(lane), .precede(precede)
  );

  nsort_rank #(.N(N), .RW(RW)) u_rank (
    .precede(precede), .rank(rank)
  );

  nsort_sop_mux #(.N(N), .W(W), .RW(RW)) u_mux (
    .lane(lane), .rank(rank), .sel(sel), .sorted(sorted)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic           hold_v;
      logic [N*W-1:0] hold_d;
      assign in_ready = !hold_v || out_ready;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hold_v <= 1'b0;
          hold_d <= '0;
        end else if (in_ready) begin
          hold_v <= in_valid;
          if (in_valid) hold_d <= sorted;
        end
      end
      assign out_valid = hold_v;
      assign out_data  = hold_d;
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = sorted;
    end
  endgenerate
endmodule

// File: rtl/nsort_chk.sv
module nsort_chk #(
  parameter int N       = 16,
  parameter int W       = 32,
  parameter bit DESCEND = 1'b0,
  parameter bit OUT_REG = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [N*W-1:0]      out_data,
  input logic [N-1:0][N-1:0] sel
);
  logic ordered;
  always_comb begin
    ordered = 1'b1;
    for (int k = 1; k < N; k++) begin
      if (DESCEND) begin
        if (out_data[(k-1)*W +: W] < out_data[k*W +: W]) ordered = 1'b0;
      end else begin
        if (out_data[(k-1)*W +: W] > out_data[k*W +: W]) ordered = 1'b0;
      end
    end
  end

  // R1 R4
  order_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ordered);

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_sel
      // R5
      one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel[k]) == 1);
    end
    if (OUT_REG) begin : g_reg
      // R6
      accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
      // R7
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      // R8
      ready_low_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));
      // R9
      reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
    end
  endgenerate
endmodule

bind nsort_top nsort_chk #(.N(N), .W(W), .DESCEND(DESCEND), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .sel(sel)
);

// File: tb/nsort_top_tb.sv
module nsort_top_tb;
  localparam int CLK_P = 10;
  localparam int N = 16;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           out_ready = 1'b1;
  logic [N*W-1:0] in_data = '0;
  logic           in_ready, in_ready_d;
  logic           out_valid, out_valid_d;
  logic [N*W-1:0] out_data, out_data_d;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  // R10: default configuration (16 lanes of 32 bits)
  nsort_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
  nsort_top #(.DESCEND(1'b1)) u_dut_dn (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_d),
    .in_data(in_data), .out_valid(out_valid_d), .out_ready(out_ready), .out_data(out_data_d)
  );

  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v, input bit dn);
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N-1-i; j++) begin
        if (dn ? (a[j] < a[j+1]) : (a[j] > a[j+1])) begin
          t = a[j]; a[j] = a[j+1]; a[j+1] = t;
        end
      end
    end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one group, let it be accepted, check both directions one cycle later.
  task automatic send_check(input logic [N*W-1:0] v, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {"R6 ", req}, {{(N*W-1){1'b0}}, out_valid}, 1);
    check(out_data == ref_sort(v, 1'b0), {"R1 R2 ", req}, out_data, ref_sort(v, 1'b0));
    check(out_data_d == ref_sort(v, 1'b1), {"R4 R2 ", req}, out_data_d, ref_sort(v, 1'b1));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] v, va, vb;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9 during reset", {{(N*W-1){1'b0}}, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9 after reset", {{(N*W-1){1'b0}}, out_valid}, 0);

    // R3: all equal
    for (int i = 0; i < N; i++) v[i*W +: W] = 32'h0000_5a5a;
    send_check(v, "R3 all equal");
    for (int i = 0; i < N; i++) v[i*W +: W] = 32'hffff_ffff;
    send_check(v, "R3 all ones");

    // ascending input, reversed input, extremes
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i * 3);
    send_check(v, "R10 presorted");
    for (int i = 0; i < N; i++) v[i*W +: W] = W'((N - i) * 7);
    send_check(v, "R10 reversed");
    for (int i = 0; i < N; i++) v[i*W +: W] = (i % 2) ? 32'hffff_ffff : 32'h0;
    send_check(v, "R2 extremes");

    // random full range
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = $urandom;
      send_check(v, "R1 random");
    end
    // many duplicates
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom % 4) << 30;
      send_check(v, "R2 duplicates");
    end

    // R7 R8: back-pressure
    for (int i = 0; i < N; i++) va[i*W +: W] = $urandom;
    for (int i = 0; i < N; i++) vb[i*W +: W] = W'($urandom % 5);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = va;
    @(posedge clk);
    @(negedge clk);
    in_data = vb;
    for (int c = 0; c < 4; c++) begin
      check(in_ready == 1'b0, "R8 ready low while stalled", {{(N*W-1){1'b0}}, in_ready}, 0);
      check(out_valid && out_data == ref_sort(va, 1'b0), "R7 held group", out_data, ref_sort(va, 1'b0));
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == ref_sort(vb, 1'b0), "R6 R7 next after drain", out_data, ref_sort(vb, 1'b0));
    @(negedge clk);
    check(out_valid == 1'b0, "R6 idle after drain", {{(N*W-1){1'b0}}, out_valid}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule